// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block takes a single write to a master command register and carries it out as an ordered chain of byte-level I2C operations. The command word holds independent flags for START (with the address byte), data transmit, data receive (with an optional final NAK) and STOP. The sequencer works through whichever flags are set, issues one request at a time to a byte-level bus engine, waits for that engine's completion, and records the outcome in a set of sticky status flags. Software reads back the command word, including a 4-bit transfer-state field that reflects where the bus transaction stands.

The bus engine takes care of bit timing on SCL and SDA and sits outside this block. The sequencer asks it to generate a START and shift out an address byte, send a data byte, receive a byte, send a NAK, or generate a STOP, and it gets back a done pulse with an acknowledge bit and, for a receive, the received byte. A busy output stays high from the moment a command is accepted until every flag it can act on has been dealt with. While busy is high, further command writes are dropped.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command write is accepted only when at least one of `master_en` or `slave_en` is high and `busy` is low. Any other command write changes neither `cmd_rd` nor `busy`, and it starts no engine request.
- R2: An accepted write replaces `cmd_rd[15:0]` with `cmd_wdata`, bits not used as flags included. `busy` is high in the cycle after acceptance and stays high until no actionable flag remains.
- R3: Flag bits are START=0, TX=1, RX=3, RX-last=4 and STOP=5. They are processed in the order START, TX, RX, STOP, and each one clears itself once it has been handled. While `busy` is high, no bit of `cmd_rd[15:0]` ever goes from 0 to 1.
- R4: The transfer state sits in `cmd_rd[22:19]`, encoded as IDLE=0x0, ACTIVE=0x8, START=0x9, RESTART=0xA, STOP=0xB, TXD=0xC and RXD=0xE. START enters RESTART when state bit 3 is already set, and enters START otherwise. The address request carries `tx_byte`, with the 7-bit target address in bits 7:1 and the read flag in bit 0. The TX flag is cleared together with START.
- R5: An acknowledged address or data byte sets status bit 0. A NAK on either sets status bit 1.
- R6: When the address is NAKed, the sequence stops. No further request is issued, the RX and STOP flags stay set, the state keeps its START or RESTART value, and `busy` falls.
- R7: A data transmit runs in state TXD. If the byte is NAKed, a STOP request follows. Afterwards the state is ACTIVE.
- R8: A receive runs in state RXD. The received byte appears on `rx_byte` and status bit 2 is set. When RX-last is set, a NAK request follows. RX and RX-last are then both cleared and the state becomes ACTIVE.
- R9: A receive flag that arrives while status bit 2 is still set is not executed, and it stays set in `cmd_rd`.
- R10: STOP with state bit 3 clear sets status bit 5 and issues no request. Otherwise STOP issues a stop request in state STOP and sets status bit 4. In both cases the state then becomes IDLE.
- R11: Writing `sts_clr_we` with a mask clears the masked status bits and leaves the other bits untouched.
- R12: The engine request is a one-cycle pulse. No new request is issued before the previous one has returned `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Master function enable |
| slave_en | input | 1 | Slave function enable (counts only towards acceptance) |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word written to the low half |
| tx_byte | input | 8 | Byte buffer: address byte for START, data byte for TX |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 6 | Status bits to clear when the strobe is high |
| cmd_rd | output | 32 | Command register readback: flags [15:0], state [22:19] |
| status | output | 6 | Sticky status flags |
| rx_byte | output | 8 | Last byte received |
| busy | output | 1 | Command in progress |
| eng_req | output | 1 | One-cycle request to the bus engine |
| eng_op | output | 3 | Requested operation: 1 start, 2 send, 3 receive, 4 NAK, 5 stop |
| eng_wdata | output | 8 | Byte for a start or send request |
| eng_done | input | 1 | Engine completion pulse |
| eng_ack | input | 1 | Target acknowledged (valid with done) |
| eng_rdata | input | 8 | Received byte (valid with done) |

## Verification
The hardest paths to reach from the ports are those that depend on the state left behind by earlier commands. A deferred receive needs an RX-done flag that software has not yet cleared. An abnormal STOP needs an idle state. A repeated START needs a state still active from the previous command. A transmit NAK followed by an extra STOP needs a transfer that was left open. The stimulus therefore runs as one continuous scenario, with no reset between commands. Status is cleared selectively or not at all, so each of these situations is set up by the commands that come before it. The bench's engine model returns scripted ACK or NAK answers, and at every request it checks the operation, the byte and the state field.

// File: rtl/i2cs_pkg.sv
// Shared encodings for the I2C master command sequencer.
// Field positions are fixed by software's view of the command word.
package i2cs_pkg;
    localparam int CMD_W     = 16;  // writable low half of command word
    localparam int RD_W      = 32;  // full readback width
    localparam int STATE_W   = 4;
    localparam int STATE_LSB = 19;
    localparam int STS_W     = 6;

    // command flag positions
    localparam int F_START = 0;
    localparam int F_TX    = 1;
    localparam int F_RX    = 3;
    localparam int F_LAST  = 4;
    localparam int F_STOP  = 5;

    // status flag positions
    localparam int S_ACK   = 0;
    localparam int S_NAK   = 1;
    localparam int S_RXD   = 2;
    localparam int S_NSTOP = 4;
    localparam int S_ABN   = 5;

    typedef enum logic [STATE_W-1:0] {
        XS_IDLE    = 4'h0,
        XS_ACTIVE  = 4'h8,
        XS_START   = 4'h9,
        XS_RESTART = 4'hA,
        XS_STOP    = 4'hB,
        XS_TXD     = 4'hC,
        XS_RXD     = 4'hE
    } xfer_state_t;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_SEND  = 3'd2,
        OP_RECV  = 3'd3,
        OP_NAK   = 3'd4,
        OP_STOP  = 3'd5
    } eng_op_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DISP, PH_W_START, PH_W_TX, PH_W_TXEND,
        PH_W_RX, PH_W_NAK, PH_W_STOP
    } phase_t;

    typedef enum logic [2:0] {
        PK_NONE, PK_START, PK_TX, PK_RX, PK_STOP
    } pick_t;
endpackage

// File: rtl/i2cs_status.sv
// Sticky status flags: set pulses from the sequencer, write-1-to-clear
// from software. A set in the same cycle as a clear wins.
module i2cs_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_eff;

    // Clear mask applies only with its strobe.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_eff) | set_pulse;
    end
endmodule

// File: rtl/i2cs_seq.sv
// Command flag sequencer. Holds the low command half and the transfer
// state, picks the next flag in START, TX, RX, STOP order, issues one
// engine request and waits for its done pulse.
// Assumes the engine never returns done in the cycle of its request.
module i2cs_seq
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_done_flag,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              busy,
    output logic [CMD_W-1:0]  flags,
    output xfer_state_t       xstate,
    output logic              eng_req,
    output eng_op_t           eng_op,
    output logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] rx_byte,
    output logic [STS_W-1:0]  sts_set
);
    phase_t phase;
    pick_t  pick;
    logic   rx_pend;

    // Choose the highest-priority flag still to be acted on.
    always_comb begin
        rx_pend = flags[F_RX] | flags[F_LAST];
        if (flags[F_START])                  pick = PK_START;
        else if (flags[F_TX])                pick = PK_TX;
        else if (rx_pend && !rx_done_flag)   pick = PK_RX;
        else if (flags[F_STOP])              pick = PK_STOP;
        else                                 pick = PK_NONE;
    end

    // Status set pulses, aligned with the state update.
    always_comb begin
        sts_set = '0;
        case (phase)
            PH_W_START, PH_W_TX:
                if (eng_done) sts_set[eng_ack ? S_ACK : S_NAK] = 1'b1;
            PH_W_RX:
                if (eng_done) sts_set[S_RXD] = 1'b1;
            PH_W_STOP:
                if (eng_done) sts_set[S_NSTOP] = 1'b1;
            PH_DISP:
                if (pick == PK_STOP && !xstate[3]) sts_set[S_ABN] = 1'b1;
            default: ;
        endcase
    end

    // Sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            busy      <= 1'b0;
            flags     <= '0;
            xstate    <= XS_IDLE;
            eng_req   <= 1'b0;
            eng_op    <= OP_NONE;
            eng_wdata <= '0;
            rx_byte   <= '0;
        end else begin
            eng_req <= 1'b0;
            case (phase)
                PH_IDLE: if (accept) begin
                    flags <= cmd_wdata;
                    busy  <= 1'b1;
                    phase <= PH_DISP;
                end
                PH_DISP: case (pick)
                    PK_START: begin
                        xstate    <= xstate[3] ? XS_RESTART : XS_START;
                        eng_req   <= 1'b1;
                        eng_op    <= OP_START;
                        eng_wdata <= tx_byte;
                        phase     <= PH_W_START;
                    end
                    PK_TX: begin
                        xstate    <= XS_TXD;
                        eng_req   <= 1'b1;
                        eng_op    <= OP_SEND;
                        eng_wdata <= tx_byte;
                        phase     <= PH_W_TX;
                    end
                    PK_RX: begin
                        xstate  <= XS_RXD;
                        eng_req <= 1'b1;
                        eng_op  <= OP_RECV;
                        phase   <= PH_W_RX;
                    end
                    PK_STOP: begin
                        if (xstate[3]) begin
                            xstate  <= XS_STOP;
                            eng_req <= 1'b1;
                            eng_op  <= OP_STOP;
                            phase   <= PH_W_STOP;
                        end else begin
                            xstate        <= XS_IDLE;
                            flags[F_STOP] <= 1'b0;
                        end
                    end
                    default: begin
                        busy  <= 1'b0;
                        phase <= PH_IDLE;
                    end
                endcase
                PH_W_START: if (eng_done) begin
                    flags[F_START] <= 1'b0;
                    flags[F_TX]    <= 1'b0;
                    if (eng_ack) begin
                        xstate <= XS_ACTIVE;
                        phase  <= PH_DISP;
                    end else begin
                        busy  <= 1'b0;
                        phase <= PH_IDLE;
                    end
                end
                PH_W_TX: if (eng_done) begin
                    flags[F_TX] <= 1'b0;
                    if (eng_ack) begin
                        xstate <= XS_ACTIVE;
                        phase  <= PH_DISP;
                    end else begin
                        eng_req <= 1'b1;
                        eng_op  <= OP_STOP;
                        phase   <= PH_W_TXEND;
                    end
                end
                PH_W_TXEND: if (eng_done) begin
                    xstate <= XS_ACTIVE;
                    phase  <= PH_DISP;
                end
                PH_W_RX: if (eng_done) begin
                    rx_byte <= eng_rdata;
                    if (flags[F_LAST]) begin
                        eng_req <= 1'b1;
                        eng_op  <= OP_NAK;
                        phase   <= PH_W_NAK;
                    end else begin
                        flags[F_RX] <= 1'b0;
                        xstate      <= XS_ACTIVE;
                        phase       <= PH_DISP;
                    end
                end
                PH_W_NAK: if (eng_done) begin
                    flags[F_RX]   <= 1'b0;
                    flags[F_LAST] <= 1'b0;
                    xstate        <= XS_ACTIVE;
                    phase         <= PH_DISP;
                end
                PH_W_STOP: if (eng_done) begin
                    flags[F_STOP] <= 1'b0;
                    xstate        <= XS_IDLE;
                    phase         <= PH_DISP;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
// Top of the I2C master command sequencer: acceptance gate, flag
// sequencer and sticky status. Bit timing lives in the external engine.
module i2c_cmd_sequencer
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              slave_en,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_wdata,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sts_clr_we,
    input  logic [5:0]        sts_clr_mask,
    output logic [31:0]       cmd_rd,
    output logic [5:0]        status,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata
);
    localparam int HI_PAD  = RD_W - STATE_LSB - STATE_W;
    localparam int MID_PAD = STATE_LSB - CMD_W;

    logic             accept;
    logic [CMD_W-1:0] flags;
    xfer_state_t      xstate;
    eng_op_t          op_q;
    logic [STS_W-1:0] sts_set;

    // Accept a command only when enabled and idle.
    always_comb accept = cmd_we && (master_en || slave_en) && !busy;

    i2cs_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .cmd_wdata    (cmd_wdata),
        .tx_byte      (tx_byte),
        .rx_done_flag (status[S_RXD]),
        .eng_done     (eng_done),
        .eng_ack      (eng_ack),
        .eng_rdata    (eng_rdata),
        .busy         (busy),
        .flags        (flags),
        .xstate       (xstate),
        .eng_req      (eng_req),
        .eng_op       (op_q),
        .eng_wdata    (eng_wdata),
        .rx_byte      (rx_byte),
        .sts_set      (sts_set)
    );

    i2cs_status #(.W(STS_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (sts_set),
        .clr_we    (sts_clr_we),
        .clr_mask  (sts_clr_mask),
        .flags     (status)
    );

    // Readback word and engine opcode.
    always_comb begin
        cmd_rd = {{HI_PAD{1'b0}}, xstate, {MID_PAD{1'b0}}, flags};
        eng_op = op_q;
    end
endmodule

// File: rtl/i2cs_checker.sv
// Port-level properties of the command sequencer, bound to its top.
module i2cs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        master_en,
    input logic        slave_en,
    input logic        cmd_we,
    input logic        busy,
    input logic [31:0] cmd_rd,
    input logic [5:0]  status,
    input logic        eng_req,
    input logic [2:0]  eng_op,
    input logic        eng_done
);
    logic pend;

    // Track an engine request that has not yet completed.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (eng_req)  pend <= 1'b1;
        else if (eng_done) pend <= 1'b0;
    end

    a_r1_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !master_en && !slave_en && !busy) |=> !busy);

    a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (master_en || slave_en) && !busy) |=> busy);

    a_r3_flags_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((cmd_rd[15:0] & ~$past(cmd_rd[15:0])) == 16'h0));

    a_r4_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 3'd1) |-> (cmd_rd[22:19] == 4'h9 || cmd_rd[22:19] == 4'hA));

    a_r10_abnormal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> (cmd_rd[22:19] == 4'h0));

    a_r12_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !pend);

    a_r12_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
endmodule

bind i2c_cmd_sequencer i2cs_checker u_i2cs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .slave_en  (slave_en),
    .cmd_we    (cmd_we),
    .busy      (busy),
    .cmd_rd    (cmd_rd),
    .status    (status),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_done  (eng_done)
);

// File: tb/test_i2c_cmd_sequencer.sv
`timescale 1ns/1ps
module test_i2c_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0, slave_en = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  tx_byte = '0;
    logic        sts_clr_we = 1'b0;
    logic [5:0]  sts_clr_mask = '0;
    logic [31:0] cmd_rd;
    logic [5:0]  status;
    logic [7:0]  rx_byte;
    logic        busy;
    logic        eng_req;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_done = 1'b0;
    logic        eng_ack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    i2c_cmd_sequencer i_i2c_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .slave_en(slave_en),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .tx_byte(tx_byte),
        .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .cmd_rd(cmd_rd), .status(status), .rx_byte(rx_byte), .busy(busy),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // reference model state
    logic [3:0]  m_state = 4'h0;
    logic [5:0]  m_sts = '0;
    logic [7:0]  m_rx = '0;
    logic [15:0] m_flags = '0;
    int          exp_op[$];
    logic [7:0]  exp_wd[$];
    logic [3:0]  exp_st[$];
    bit          rsp_ack[$];
    logic [7:0]  rsp_rd[$];
    int          eng_cnt = 0;
    bit          cur_ack;
    logic [7:0]  cur_rd;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push_op(input int op, input logic [7:0] wd, input logic [3:0] st,
                           input bit a, input logic [7:0] rd);
        exp_op.push_back(op); exp_wd.push_back(wd); exp_st.push_back(st);
        rsp_ack.push_back(a); rsp_rd.push_back(rd);
    endtask

    // Behavioural prediction of one accepted command.
    task automatic predict(input logic [15:0] f, input logic [7:0] txb,
                           input bit a_start, input bit a_tx, input logic [7:0] rd);
        logic [3:0] st;
        m_flags = f;
        if (m_flags[0]) begin
            st = m_state[3] ? 4'hA : 4'h9;
            push_op(1, txb, st, a_start, 8'h00);
            m_flags[0] = 1'b0; m_flags[1] = 1'b0;
            if (a_start) begin m_sts[0] = 1'b1; m_state = 4'h8; end
            else begin m_sts[1] = 1'b1; m_state = st; return; end
        end
        if (m_flags[1]) begin
            push_op(2, txb, 4'hC, a_tx, 8'h00);
            m_flags[1] = 1'b0;
            if (a_tx) m_sts[0] = 1'b1;
            else begin m_sts[1] = 1'b1; push_op(5, 8'h00, 4'hC, 1'b1, 8'h00); end
            m_state = 4'h8;
        end
        if ((m_flags[3] || m_flags[4]) && !m_sts[2]) begin
            push_op(3, 8'h00, 4'hE, 1'b1, rd);
            m_rx = rd; m_sts[2] = 1'b1;
            if (m_flags[4]) push_op(4, 8'h00, 4'hE, 1'b1, 8'h00);
            m_flags[3] = 1'b0; m_flags[4] = 1'b0;
            m_state = 4'h8;
        end
        if (m_flags[5]) begin
            if (!m_state[3]) m_sts[5] = 1'b1;
            else begin push_op(5, 8'h00, 4'hB, 1'b1, 8'h00); m_sts[4] = 1'b1; end
            m_flags[5] = 1'b0;
            m_state = 4'h0;
        end
    endtask

    // Bus engine model, checked against the prediction on every clock.
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done = 1'b1; eng_ack = cur_ack; eng_rdata = cur_rd;
            end
        end
        if (rst_n && eng_req) begin
            chk(eng_cnt == 0, "R12", "request while one outstanding", eng_cnt, 0);
            if (exp_op.size() == 0) begin
                chk(1'b0, "R3", "unexpected engine op", eng_op, 0);
                cur_ack = 1'b1; cur_rd = 8'h00;
            end else begin
                chk(eng_op == exp_op[0][2:0], "R3", "engine op order", eng_op, exp_op[0]);
                chk(cmd_rd[22:19] == exp_st[0], "R4", "state at request", cmd_rd[22:19], exp_st[0]);
                if (exp_op[0] == 1 || exp_op[0] == 2)
                    chk(eng_wdata == exp_wd[0], "R4", "request byte", eng_wdata, exp_wd[0]);
                cur_ack = rsp_ack[0]; cur_rd = rsp_rd[0];
                void'(exp_op.pop_front()); void'(exp_wd.pop_front()); void'(exp_st.pop_front());
                void'(rsp_ack.pop_front()); void'(rsp_rd.pop_front());
            end
            eng_cnt = 3;
        end
    end

    task automatic final_cmp(input string req);
        logic [31:0] e;
        e = {9'h0, m_state, 3'h0, m_flags};
        chk(cmd_rd == e, req, "cmd readback", cmd_rd, e);
        chk(status == m_sts, req, "status", {26'h0, status}, {26'h0, m_sts});
        chk(rx_byte == m_rx, req, "rx byte", {24'h0, rx_byte}, {24'h0, m_rx});
        chk(exp_op.size() == 0, req, "ops left unissued", exp_op.size(), 0);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 500) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [15:0] f, input logic [7:0] txb, input bit a_start,
                           input bit a_tx, input logic [7:0] rd, input bit acc, input string req);
        if (acc) predict(f, txb, a_start, a_tx, rd);
        @(negedge clk);
        cmd_wdata = f; tx_byte = txb; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(busy == acc, acc ? "R2" : "R1", "busy after write", busy, acc);
        wait_idle();
        final_cmp(req);
    endtask

    task automatic clr_sts(input logic [5:0] m);
        @(negedge clk);
        sts_clr_we = 1'b1; sts_clr_mask = m;
        @(negedge clk);
        sts_clr_we = 1'b0;
        m_sts = m_sts & ~m;
        chk(status == m_sts, "R11", "status after clear", status, m_sts);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(cmd_rd == 32'h0, "R2", "reset cmd readback", cmd_rd, 0);
        chk(status == 6'h0, "R11", "reset status", status, 0);
        chk(!busy && !eng_req, "R12", "reset busy/req", {busy, eng_req}, 0);

        // R1: both enables low, write dropped
        run_cmd(16'h0021, 8'hA4, 1, 1, 8'h00, 0, "R1");
        master_en = 1'b1;
        // R10: STOP from IDLE -> abnormal; R2: unused bit 7 kept
        run_cmd(16'h00A0, 8'h00, 1, 1, 8'h00, 1, "R10");
        clr_sts(6'h3F);
        // R4: START with TX flag, ack -> TX dropped, ACTIVE
        run_cmd(16'h0003, 8'hA4, 1, 1, 8'h00, 1, "R4");
        // R5: data transmit acked
        run_cmd(16'h0002, 8'h3C, 1, 1, 8'h00, 1, "R5");
        // R8: restart read, RX with last, STOP
        run_cmd(16'h0039, 8'hA5, 1, 1, 8'h5A, 1, "R8");
        clr_sts(6'h11);  // R11 partial clear leaves RX-done
        // R9: RX while RX-done still set is deferred
        run_cmd(16'h0029, 8'hA5, 1, 1, 8'h00, 1, "R9");
        clr_sts(6'h3F);
        // R6: address NAK aborts, RX and STOP stay
        run_cmd(16'h0029, 8'h90, 0, 1, 8'h00, 1, "R6");
        // R7: data NAK ends the transfer
        run_cmd(16'h0002, 8'h77, 1, 0, 8'h00, 1, "R7");

        // R1: write while busy is dropped
        predict(16'h0021, 8'h40, 1, 1, 8'h00);
        @(negedge clk);
        cmd_wdata = 16'h0021; tx_byte = 8'h40; cmd_we = 1'b1;
        @(negedge clk);
        cmd_wdata = 16'h0008;
        chk(busy, "R2", "busy after accept", busy, 1);
        @(negedge clk);
        cmd_we = 1'b0;
        wait_idle();
        final_cmp("R1");

        // R1: slave enable alone accepts; STOP from IDLE is abnormal (R10)
        master_en = 1'b0; slave_en = 1'b1;
        run_cmd(16'h0020, 8'h00, 1, 1, 8'h00, 1, "R10");
        slave_en = 1'b0;
        run_cmd(16'h0001, 8'h12, 1, 1, 8'h00, 0, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule